// File: doc/BRIEF.md
# Zero-Run Byte Expander

This block sits in a configuration load path and restores a byte stream that was packed by replacing runs of zero bytes with short codes. Three programmable code bytes stand for runs of eight, four and two zero bytes. When one of them arrives on the input and expansion is switched on, the block emits that many `0x00` bytes, one per cycle. Every other byte is copied to the output unchanged.

Both sides use a valid/ready handshake. The output is held in a register. While a run is being emitted, the block refuses new input. A stalled output freezes both the run and the held byte, so nothing is lost.

The three codes arrive together in one wide configuration word, and a separate flag switches expansion on. Both come from a command decoder upstream. A code byte of `0xFF` turns that code off. If two codes are given the same value, the longer run wins.

Top module: `zero_run_expander`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `out_valid` is 0. With `out_ready` high, `in_ready` is 1.
- R2: With `cmp_en` low, every accepted byte appears once on the output, unchanged, including bytes equal to a programmed code.
- R3: With `cmp_en` high, a byte equal to the long code `cmp_cfg[23:16]` (other than `0xFF`) becomes exactly eight `0x00` bytes.
- R4: With `cmp_en` high, a byte equal to the middle code `cmp_cfg[15:8]` (other than `0xFF`) becomes exactly four `0x00` bytes.
- R5: With `cmp_en` high, a byte equal to the short code `cmp_cfg[7:0]` (other than `0xFF`) becomes exactly two `0x00` bytes.
- R6: A code byte set to `0xFF` is never expanded. An input byte `0xFF` always comes out as a single `0xFF`.
- R7: A byte that matches no active code comes out unchanged, and output order follows input order.
- R8: When several codes share one non-`0xFF` value, that byte expands to the longest of their runs.
- R9: While zeros of a run are still pending after the one on the output, `in_ready` is 0.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change. No byte is dropped or repeated.
- R11: Bits 55:24 of `cmp_cfg` have no effect on the output stream.
- R12: With `out_ready` held high, a run of N zeros keeps `in_ready` low for exactly N-1 cycles after the code byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_en | input | 1 | Expansion enable |
| cmp_cfg | input | 56 | Code word: [23:16] long code, [15:8] middle code, [7:0] short code; upper bits ignored |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high together with `in_valid` |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid (registered) |
| out_ready | input | 1 | Downstream can take a byte |
| out_data | output | 8 | Output byte (registered) |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, three codes, and a longest run of 8. With these values the run counter is 3 bits wide and loads 7, 3 or 1, so every run length and the counter's full range are exercised. Random output backpressure lands on pass-through bytes and on every position inside a run. Code words with duplicated values, `0xFF` entries and random upper bits cover the priority, disable and ignore rules.

// File: rtl/zrx_pkg.sv
package zrx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CODE_OFF = 8'hFF;

  // Run length for slot i: the longest run halves with each slot.
  function automatic int slot_run_len(input int longest, input int slot);
    return longest >> slot;
  endfunction
endpackage

// File: rtl/zrx_code_match.sv
module zrx_code_match #(
  parameter int DATA_W  = zrx_pkg::BYTE_W,
  parameter int N_CODES = 3,
  parameter logic [DATA_W-1:0] OFF_VAL = zrx_pkg::CODE_OFF,
  localparam int IDX_W  = (N_CODES > 1) ? $clog2(N_CODES) : 1
) (
  input  logic [DATA_W-1:0]         byte_in,
  input  logic [N_CODES*DATA_W-1:0] codes,
  output logic                      hit,
  output logic [IDX_W-1:0]          hit_idx
);
  logic [N_CODES-1:0] match;

  genvar gi;
  generate
    for (gi = 0; gi < N_CODES; gi++) begin : g_cmp
      logic [DATA_W-1:0] code_v;
      assign code_v    = codes[(N_CODES-gi)*DATA_W-1 -: DATA_W];
      assign match[gi] = (code_v != OFF_VAL) && (byte_in == code_v);
    end
  endgenerate

  // Lowest slot index is the longest run and has priority.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int k = N_CODES - 1; k >= 0; k--) begin
      if (match[k]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/zrx_run_counter.sv
module zrx_run_counter #(
  parameter int LONG_RUN = 8,
  parameter int N_CODES  = 3,
  localparam int IDX_W   = (N_CODES > 1) ? $clog2(N_CODES) : 1,
  localparam int CNT_W   = (LONG_RUN > 2) ? $clog2(LONG_RUN) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] load_idx,
  input  logic             step,
  output logic             busy
);
  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] reload [N_CODES];

  genvar gi;
  generate
    for (gi = 0; gi < N_CODES; gi++) begin : g_len
      assign reload[gi] = CNT_W'(zrx_pkg::slot_run_len(LONG_RUN, gi) - 1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (load) begin
      left_q <= reload[load_idx];
    end else if (step && left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign busy = (left_q != '0);
endmodule

// File: rtl/zrx_out_reg.sv
module zrx_out_reg #(
  parameter int DATA_W = zrx_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              take,
  output logic              can_load,
  output logic              valid_q,
  output logic [DATA_W-1:0] data_q
);
  assign can_load = !valid_q || take;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load && can_load) begin
      valid_q <= 1'b1;
      data_q  <= load_data;
    end else if (take) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/zero_run_expander.sv
module zero_run_expander #(
  parameter int DATA_W   = 8,
  parameter int N_CODES  = 3,
  parameter int LONG_RUN = 8,
  parameter int CFG_W    = 56,
  localparam int CODE_BITS = N_CODES * DATA_W,
  localparam int IDX_W     = (N_CODES > 1) ? $clog2(N_CODES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_en,
  input  logic [CFG_W-1:0]  cmp_cfg,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic              code_hit;
  logic [IDX_W-1:0]  code_idx;
  logic              run_busy;
  logic              slot_free;
  logic              accept;
  logic              expand;
  logic              load_out;
  logic [DATA_W-1:0] load_byte;
  logic              cfg_unused;

  assign cfg_unused = ^cmp_cfg[CFG_W-1:CODE_BITS];

  zrx_code_match #(
    .DATA_W (DATA_W),
    .N_CODES(N_CODES),
    .OFF_VAL({DATA_W{1'b1}})
  ) u_match (
    .byte_in(in_data),
    .codes  (cmp_cfg[CODE_BITS-1:0]),
    .hit    (code_hit),
    .hit_idx(code_idx)
  );

  assign in_ready  = slot_free && !run_busy;
  assign accept    = in_valid && in_ready;
  assign expand    = accept && cmp_en && code_hit;
  assign load_out  = accept || run_busy;
  assign load_byte = (expand || run_busy) ? '0 : in_data;

  zrx_run_counter #(
    .LONG_RUN(LONG_RUN),
    .N_CODES (N_CODES)
  ) u_run (
    .clk     (clk),
    .rst     (rst),
    .load    (expand),
    .load_idx(code_idx),
    .step    (run_busy && slot_free),
    .busy    (run_busy)
  );

  zrx_out_reg #(
    .DATA_W(DATA_W)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .load     (load_out),
    .load_data(load_byte),
    .take     (out_ready),
    .can_load (slot_free),
    .valid_q  (out_valid),
    .data_q   (out_data)
  );
endmodule

// File: rtl/zrx_checks.sv
module zrx_checks #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmp_en,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              run_busy
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !out_valid); // R1

  AST_PASS_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !cmp_en) |=> (out_valid && out_data == $past(in_data))); // R2

  AST_RUN_EMITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    run_busy |-> (out_valid && out_data == '0)); // R3

  AST_FF_PASSES: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_data == {DATA_W{1'b1}}) |=> (out_valid && out_data == {DATA_W{1'b1}})); // R6

  AST_NO_INPUT_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    run_busy |-> !in_ready); // R9

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10
endmodule

bind zero_run_expander zrx_checks #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmp_en   (cmp_en),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_data  (in_data),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .run_busy (run_busy)
);

// File: tb/zero_run_expander_test.sv
`timescale 1ns/1ps
module zero_run_expander_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmp_en = 1'b0;
  logic [55:0] cmp_cfg = 56'h00FFFFFF_FFFFFF;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;

  int    errors = 0;
  int    checks = 0;
  string req = "R1";
  bit    bp_on = 1'b0;
  bit    done = 1'b0;
  logic [7:0] expq[$];

  always #4 clk = ~clk;

  zero_run_expander uut (
    .clk(clk), .rst(rst), .cmp_en(cmp_en), .cmp_cfg(cmp_cfg),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input string r, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // Expected run length of a byte (1 = passes through as itself).
  function automatic int model_len(input logic [7:0] b);
    if (!cmp_en) return 1;
    if (cmp_cfg[23:16] != 8'hFF && b == cmp_cfg[23:16]) return 8;
    if (cmp_cfg[15:8]  != 8'hFF && b == cmp_cfg[15:8])  return 4;
    if (cmp_cfg[7:0]   != 8'hFF && b == cmp_cfg[7:0])   return 2;
    return 1;
  endfunction

  // Output backpressure, driven just after each rising edge.
  always @(posedge clk) begin
    #1 out_ready = bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  // Monitor: scoreboard compare plus stall hold check.
  bit         stall_prev = 1'b0;
  logic [7:0] stall_data = 8'h00;
  always @(negedge clk) begin
    if (!rst) begin
      if (stall_prev)
        check("R10", out_valid && out_data == stall_data, out_data, stall_data);
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(req, 1'b0, out_data, 0);
        end else begin
          logic [7:0] e;
          e = expq.pop_front();
          check(req, out_data == e, out_data, e);
        end
      end
      stall_prev = out_valid && !out_ready;
      stall_data = out_data;
    end
  end

  task automatic send(input logic [7:0] b);
    int  n;
    bit  acc;
    n = model_len(b);
    if (n == 1) expq.push_back(b);
    else for (int k = 0; k < n; k++) expq.push_back(8'h00);
    in_valid = 1'b1;
    in_data  = b;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      acc = in_ready;
      @(posedge clk);
    end
    #1 in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 400; k++) begin
      if (expq.size() == 0 && !out_valid) break;
      @(posedge clk);
    end
    #1;
    check({req, " drain"}, expq.size() == 0, expq.size(), 0);
  endtask

  // R9/R12: count cycles in_ready stays low after a code byte is taken.
  task automatic run_timing(input logic [7:0] b, input int low_exp, input string r);
    int low;
    bit acc;
    drain();
    req = r;
    for (int k = 0; k < low_exp + 1; k++) expq.push_back(8'h00);
    in_valid = 1'b1;
    in_data  = b;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      acc = in_ready;
      @(posedge clk);
    end
    #1 in_valid = 1'b0;
    low = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (in_ready) break;
      low++;
    end
    check(r, low == low_exp, low, low_exp);
    drain();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check("R1", !out_valid, out_valid, 0);
    check("R1", in_ready, in_ready, 1);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check("R1", !out_valid && in_ready, {out_valid, in_ready}, 2'b01);
    @(posedge clk); #1;

    // R2: expansion off, codes programmed but ignored
    req = "R2"; bp_on = 1'b1;
    cmp_cfg = 56'h00FFFFFF_112233; cmp_en = 1'b0;
    foreach (expq[i]) ;
    send(8'h11); send(8'h22); send(8'h33); send(8'h00); send(8'h5A);
    drain();

    // R7, R3, R4, R5 with random backpressure
    cmp_en = 1'b1;
    req = "R7"; send(8'hA1); send(8'h00); send(8'h7E);
    req = "R3"; send(8'h11); send(8'h42);
    req = "R4"; send(8'h22); send(8'h22);
    req = "R5"; send(8'h33); send(8'hC3); send(8'h33);
    req = "R7";
    for (int k = 0; k < 40; k++) send(8'($urandom_range(0, 255)));
    drain();

    // R6: 0xFF code disables, 0xFF byte passes
    req = "R6";
    cmp_cfg = 56'h00FFFFFF_FF22FF;
    send(8'hFF); send(8'h22); send(8'hFF);
    drain();

    // R8: shared code values pick the longest run
    req = "R8";
    cmp_cfg = 56'h00FFFFFF_444444;
    send(8'h44);
    drain();
    cmp_cfg = 56'h00FFFFFF_FF6666;
    send(8'h66); send(8'h01);
    drain();

    // R11: upper configuration bits vary freely
    req = "R11";
    for (int k = 0; k < 6; k++) begin
      cmp_cfg = {32'($urandom), 24'h112233};
      send(8'h11); send(8'h22); send(8'h33); send(8'h9C);
      drain();
    end

    // R9 / R12: throughput and input stall during runs
    bp_on = 1'b0;
    @(posedge clk); #1;
    cmp_cfg = 56'h00FFFFFF_112233;
    run_timing(8'h11, 7, "R12");
    run_timing(8'h22, 3, "R9");
    run_timing(8'h33, 1, "R12");

    done = 1'b1;
  end

  initial begin
    for (int k = 0; k < 100000; k++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule